// File: doc/BRIEF.md
# Region-Based Access Protection Checker

This block sits beside a core's load/store path and judges each data access against a 16-bit protection word. It compares two addresses: the program counter and the data address. Each address is sorted into one of three memory regions: private, volatile private or shared. Anything else falls into an unguarded "none" region. For certain pairs of (code region, target region), a 2-bit mode in the protection word picks one of four outcomes:

- pass the access untouched;
- make the target read-only;
- zero the read data and discard writes;
- raise a fault.

The protection word also carries other controls:

- per-region execution traps, taken when the PC sits in a guarded region;
- traps for halt, invalid and sleep instructions;
- two lock bits that stop other cores from writing groups of this core's control registers.

Every rule applies only while the core's running input is high. When the core is halted, accesses pass untouched and nothing traps. The verdict is registered: the outputs for an access presented before a rising edge appear after that edge. Region bounds are inclusive and are parameters.

Top module: `prot_guard`

## Requirements
- R1: An address belongs to the private region when it lies in [PRIV_LO, PRIV_HI], to the volatile private region in [VPRIV_LO, VPRIV_HI], to the shared region in [SHR_LO, SHR_HI]. Otherwise it belongs to no region and is never restricted.
- R2: Mode 00 lets the access through: `wr_en` equals the write request, and `rd_zero` and `fault` stay low.
- R3: Mode 01 makes the target read-only. Writes are dropped (`wr_en` low), reads are normal, and there is no fault.
- R4: Mode 10 forces reads to zero (`rd_zero` high for a read) and drops writes, with no fault.
- R5: Mode 11 raises `fault` for both reads and writes. `wr_en` is low and `rd_zero` is high.
- R6: Mode field positions are fixed:
  - `prot[1:0]` covers private targets while the PC is in volatile private.
  - `prot[3:2]` covers private targets while the PC is in shared.
  - `prot[5:4]` covers volatile private targets while the PC is in shared.
  - Every other pair is treated as mode 00.
- R7: While running, `fault` rises whenever the PC is in a region whose execution trap bit is set:
  - `prot[8]` for private;
  - `prot[9]` for volatile private;
  - `prot[10]` for shared.
- R8: While running, `fault` rises in these instruction cases:
  - `ins_kind` 01 (halt) or 10 (invalid) with `prot[12]` set;
  - `ins_kind` 11 (sleep) with `prot[13]` set.
  - `ins_kind` 00 is an ordinary instruction.
- R9: `rmt_ok` follows `rmt_wr`, except that it is held low while running in two cases:
  - `rmt_sel` 0 or 1 (saved-exception, saved-instruction) with `prot[6]` set;
  - `rmt_sel` 2 to 5 (bank, module select, constant store, constant reload) with `prot[7]` set.
  - Codes 6 and 7 are never locked.
- R10: With `run` low, no rule applies. `wr_en` equals the write request, while `rd_zero` and `fault` stay low.
- R11: Outputs are registered one cycle after the inputs. A synchronous reset clears all outputs.
- R12: With `acc_valid` low, `wr_en` and `rd_zero` are low, and only R7/R8 can raise `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Core running; protection enabled |
| prot | input | 16 | Protection word |
| pc_addr | input | AW | Current program counter |
| ins_kind | input | 2 | Instruction class: 00 plain, 01 halt, 10 invalid, 11 sleep |
| acc_valid | input | 1 | A data access is presented |
| acc_write | input | 1 | Access is a write (else a read) |
| acc_addr | input | AW | Data access address |
| rmt_wr | input | 1 | Another core writes a control register |
| rmt_sel | input | 3 | Target control register code (see R9) |
| wr_en | output | 1 | Write may proceed |
| rd_zero | output | 1 | Read data must be replaced by zero |
| fault | output | 1 | Exception flag |
| rmt_ok | output | 1 | Remote control-register write may proceed |

## Verification
The bench sweeps every value of the six mode bits against the sixteen (code, target) region pairs, for both reads and writes. It places each address at the lowest or highest word of its region, so that an off-by-one bound or a swapped field is caught. A swapped field would move a restriction onto the wrong pair. A bound error would let an edge address escape into the "none" region. Further sweeps cover the following cases, each with the failure it targets:

- All execution-trap and instruction-trap combinations, which catch a trap bit wired to the wrong region or instruction class.
- All remote-lock combinations, which catch a lock applied to the wrong register group.
- A fully set protection word with `run` low, which exposes any rule still active while the core is halted.
- Idle cycles, which expose a write enable or a zeroed read asserted with no access presented.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;

  typedef enum logic [1:0] {
    RG_PRIV   = 2'd0,
    RG_VPRIV  = 2'd1,
    RG_SHARED = 2'd2,
    RG_NONE   = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    MD_OPEN   = 2'd0,
    MD_RDONLY = 2'd1,
    MD_ZERO   = 2'd2,
    MD_TRAP   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    IK_PLAIN = 2'd0,
    IK_HALT  = 2'd1,
    IK_BAD   = 2'd2,
    IK_SLEEP = 2'd3
  } ins_kind_e;

  localparam int PW         = 16;
  localparam int NREG       = 3;
  localparam int F_PRIV_V   = 0;
  localparam int F_PRIV_S   = 2;
  localparam int F_VPRIV_S  = 4;
  localparam int B_LOCK_EXC = 6;
  localparam int B_LOCK_CFG = 7;
  localparam int B_XGUARD   = 8;
  localparam int B_TRAP_HLT = 12;
  localparam int B_TRAP_SLP = 13;

  typedef struct packed {
    logic wr_en;
    logic rd_zero;
    logic fault;
  } verdict_t;

endpackage

// File: rtl/region_map.sv
module region_map
  import prot_guard_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] PRIV_LO  = '0,
  parameter logic [AW-1:0] PRIV_HI  = '0,
  parameter logic [AW-1:0] VPRIV_LO = '0,
  parameter logic [AW-1:0] VPRIV_HI = '0,
  parameter logic [AW-1:0] SHR_LO   = '0,
  parameter logic [AW-1:0] SHR_HI   = '0
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  localparam logic [NREG*AW-1:0] LOS = {SHR_LO, VPRIV_LO, PRIV_LO};
  localparam logic [NREG*AW-1:0] HIS = {SHR_HI, VPRIV_HI, PRIV_HI};

  logic [NREG-1:0] hit;

  // offset-from-base compare avoids a signed or always-true bound test
  for (genvar g = 0; g < NREG; g++) begin : g_win
    localparam logic [AW-1:0] LO   = LOS[g*AW +: AW];
    localparam logic [AW-1:0] SPAN = HIS[g*AW +: AW] - LOS[g*AW +: AW];
    logic [AW-1:0] off;
    assign off    = addr - LO;
    assign hit[g] = (off <= SPAN);
  end

  always_comb begin
    if (hit[0])      region = RG_PRIV;
    else if (hit[1]) region = RG_VPRIV;
    else if (hit[2]) region = RG_SHARED;
    else             region = RG_NONE;
  end
endmodule

// File: rtl/pair_mode.sv
module pair_mode
  import prot_guard_pkg::*;
(
  input  region_e       pc_rg,
  input  region_e       acc_rg,
  input  logic [PW-1:0] prot,
  output mode_e         mode
);
  always_comb begin
    mode = MD_OPEN;
    if (acc_rg == RG_PRIV && pc_rg == RG_VPRIV)
      mode = mode_e'(prot[F_PRIV_V +: 2]);
    else if (acc_rg == RG_PRIV && pc_rg == RG_SHARED)
      mode = mode_e'(prot[F_PRIV_S +: 2]);
    else if (acc_rg == RG_VPRIV && pc_rg == RG_SHARED)
      mode = mode_e'(prot[F_VPRIV_S +: 2]);
  end
endmodule

// File: rtl/access_gate.sv
module access_gate
  import prot_guard_pkg::*;
(
  input  logic     run,
  input  mode_e    mode,
  input  logic     acc_valid,
  input  logic     acc_write,
  output verdict_t verdict
);
  always_comb begin
    verdict = '0;
    if (acc_valid) begin
      if (!run) begin
        verdict.wr_en = acc_write;
      end else begin
        unique case (mode)
          MD_OPEN:   verdict.wr_en   = acc_write;
          MD_RDONLY: verdict         = '0;
          MD_ZERO:   verdict.rd_zero = !acc_write;
          MD_TRAP: begin
            verdict.rd_zero = 1'b1;
            verdict.fault   = 1'b1;
          end
          default:   verdict         = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/exec_guard.sv
module exec_guard
  import prot_guard_pkg::*;
(
  input  logic          run,
  input  region_e       pc_rg,
  input  ins_kind_e     ins_kind,
  input  logic [PW-1:0] prot,
  output logic          trap
);
  logic [NREG-1:0] xhit;
  logic            ins_trap;

  for (genvar g = 0; g < NREG; g++) begin : g_x
    assign xhit[g] = (pc_rg == region_e'(g)) && prot[B_XGUARD + g];
  end

  always_comb begin
    unique case (ins_kind)
      IK_HALT, IK_BAD: ins_trap = prot[B_TRAP_HLT];
      IK_SLEEP:        ins_trap = prot[B_TRAP_SLP];
      default:         ins_trap = 1'b0;
    endcase
  end

  assign trap = run && ((|xhit) || ins_trap);
endmodule

// File: rtl/remote_lock.sv
module remote_lock
  import prot_guard_pkg::*;
#(
  parameter int unsigned SW = 3
) (
  input  logic          run,
  input  logic          rmt_wr,
  input  logic [SW-1:0] rmt_sel,
  input  logic [PW-1:0] prot,
  output logic          ok
);
  localparam int unsigned NSEL = 1 << SW;

  logic [NSEL-1:0] locked;

  // codes 0..1: exception save group, 2..5: configuration group
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    if (g < 2) begin : g_exc
      assign locked[g] = prot[B_LOCK_EXC];
    end else if (g < 6) begin : g_cfg
      assign locked[g] = prot[B_LOCK_CFG];
    end else begin : g_free
      assign locked[g] = 1'b0;
    end
  end

  assign ok = rmt_wr && !(run && locked[rmt_sel]);
endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_guard_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] PRIV_LO  = 16'h0000,
  parameter logic [AW-1:0] PRIV_HI  = 16'h0FFF,
  parameter logic [AW-1:0] VPRIV_LO = 16'h1000,
  parameter logic [AW-1:0] VPRIV_HI = 16'h1FFF,
  parameter logic [AW-1:0] SHR_LO   = 16'h2000,
  parameter logic [AW-1:0] SHR_HI   = 16'h7FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [15:0]   prot,
  input  logic [AW-1:0] pc_addr,
  input  logic [1:0]    ins_kind,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic          rmt_wr,
  input  logic [2:0]    rmt_sel,
  output logic          wr_en,
  output logic          rd_zero,
  output logic          fault,
  output logic          rmt_ok
);
  region_e  pc_rg, acc_rg;
  mode_e    mode;
  verdict_t acc_v;
  logic     x_trap, r_ok;

  region_map #(.AW(AW), .PRIV_LO(PRIV_LO), .PRIV_HI(PRIV_HI),
               .VPRIV_LO(VPRIV_LO), .VPRIV_HI(VPRIV_HI),
               .SHR_LO(SHR_LO), .SHR_HI(SHR_HI))
    u_pc_map (.addr(pc_addr), .region(pc_rg));

  region_map #(.AW(AW), .PRIV_LO(PRIV_LO), .PRIV_HI(PRIV_HI),
               .VPRIV_LO(VPRIV_LO), .VPRIV_HI(VPRIV_HI),
               .SHR_LO(SHR_LO), .SHR_HI(SHR_HI))
    u_acc_map (.addr(acc_addr), .region(acc_rg));

  pair_mode u_mode (.pc_rg(pc_rg), .acc_rg(acc_rg), .prot(prot), .mode(mode));

  access_gate u_gate (.run(run), .mode(mode), .acc_valid(acc_valid),
                      .acc_write(acc_write), .verdict(acc_v));

  exec_guard u_xg (.run(run), .pc_rg(pc_rg), .ins_kind(ins_kind_e'(ins_kind)),
                   .prot(prot), .trap(x_trap));

  remote_lock #(.SW(3)) u_lock (.run(run), .rmt_wr(rmt_wr), .rmt_sel(rmt_sel),
                                .prot(prot), .ok(r_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      rd_zero <= 1'b0;
      fault   <= 1'b0;
      rmt_ok  <= 1'b0;
    end else begin
      wr_en   <= acc_v.wr_en;
      rd_zero <= acc_v.rd_zero;
      fault   <= acc_v.fault || x_trap;
      rmt_ok  <= r_ok;
    end
  end
endmodule

// File: rtl/prot_guard_chk.sv
module prot_guard_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic [15:0]   prot,
  input logic [AW-1:0] pc_addr,
  input logic          acc_valid,
  input logic          acc_write,
  input logic          rmt_wr,
  input logic          wr_en,
  input logic          rd_zero,
  input logic          fault,
  input logic          rmt_ok
);
  // a write is granted only for a presented write request (R2, R3, R4)
  assert_write_req_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(acc_valid && acc_write));

  // granted writes and zeroed reads never coincide (R5)
  assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_zero));

  // idle cycles leave data controls low (R12)
  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_valid) |-> (!wr_en && !rd_zero));

  // halted core: nothing restricted, nothing traps (R10)
  assert_halted_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (!fault && !rd_zero &&
                     (wr_en == $past(acc_valid && acc_write))));

  // remote grant needs a remote request (R9)
  assert_rmt_req_R9: assert property (@(posedge clk) disable iff (rst)
    rmt_ok |-> $past(rmt_wr));

  // halted core never blocks a remote write (R9, R10)
  assert_rmt_free_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(rmt_wr) && !$past(run)) |-> rmt_ok);
endmodule

bind prot_guard prot_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .prot(prot), .pc_addr(pc_addr),
  .acc_valid(acc_valid), .acc_write(acc_write), .rmt_wr(rmt_wr),
  .wr_en(wr_en), .rd_zero(rd_zero), .fault(fault), .rmt_ok(rmt_ok)
);

// File: tb/prot_guard_test.sv
module prot_guard_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [15:0] prot = '0;
  logic [7:0] pc_addr = '0;
  logic [1:0] ins_kind = '0;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [7:0] acc_addr = '0;
  logic       rmt_wr = 1'b0;
  logic [2:0] rmt_sel = '0;
  logic       wr_en, rd_zero, fault, rmt_ok;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  prot_guard #(
    .AW(8), .PRIV_LO(8'h00), .PRIV_HI(8'h3F), .VPRIV_LO(8'h40),
    .VPRIV_HI(8'h7F), .SHR_LO(8'h80), .SHR_HI(8'hDF)
  ) uut (
    .clk(clk), .rst(rst), .run(run), .prot(prot), .pc_addr(pc_addr),
    .ins_kind(ins_kind), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .rmt_wr(rmt_wr), .rmt_sel(rmt_sel),
    .wr_en(wr_en), .rd_zero(rd_zero), .fault(fault), .rmt_ok(rmt_ok)
  );

  // region 0 private, 1 volatile private, 2 shared, 3 none; edge words
  function automatic logic [7:0] pick(int rg, bit hi);
    case (rg)
      0:       return hi ? 8'h3F : 8'h00;
      1:       return hi ? 8'h7F : 8'h40;
      2:       return hi ? 8'hDF : 8'h80;
      default: return hi ? 8'hFF : 8'hE0;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b expected=%b (wr,rz,flt,rmt)", req, got, exp);
    end
  endtask

  // inputs set at negedge, result registered at posedge, sampled at next negedge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R11 reset", {wr_en, rd_zero, fault, rmt_ok}, 4'b0000);
    rst = 1'b0;

    // R1 R6 and R2..R5: all mode bits x all region pairs x read/write
    run = 1'b1; acc_valid = 1'b1;
    for (int m = 0; m < 64; m++)
      for (int pr = 0; pr < 4; pr++)
        for (int ar = 0; ar < 4; ar++)
          for (int w = 0; w < 2; w++) begin
            logic [1:0] md;
            logic [3:0] e;
            string tag;
            prot = 16'(m);
            pc_addr = pick(pr, m[0]);
            acc_addr = pick(ar, m[1] ^ w[0]);
            acc_write = w[0];
            md = 2'b00;
            if (ar == 0 && pr == 1) md = prot[1:0];
            if (ar == 0 && pr == 2) md = prot[3:2];
            if (ar == 1 && pr == 2) md = prot[5:4];
            case (md)
              2'd0: begin e = {w[0], 3'b000}; tag = "R2 R1 R6"; end
              2'd1: begin e = 4'b0000; tag = "R3 R1 R6"; end
              2'd2: begin e = {1'b0, ~w[0], 2'b00}; tag = "R4 R1 R6"; end
              default: begin e = 4'b0110; tag = "R5 R1 R6"; end
            endcase
            step();
            check(tag, {wr_en, rd_zero, fault, rmt_ok}, e);
          end

    // R10: halted core with every rule on
    run = 1'b0; prot = 16'hFFFF; ins_kind = 2'd3;
    for (int pr = 0; pr < 4; pr++)
      for (int ar = 0; ar < 4; ar++)
        for (int w = 0; w < 2; w++) begin
          pc_addr = pick(pr, 1'b0); acc_addr = pick(ar, 1'b1); acc_write = w[0];
          step();
          check("R10 halted", {wr_en, rd_zero, fault, rmt_ok}, {w[0], 3'b000});
        end

    // R12: no access, restrictive word, no traps enabled
    run = 1'b1; acc_valid = 1'b0; prot = 16'h003F; ins_kind = 2'd0;
    for (int w = 0; w < 2; w++) begin
      pc_addr = pick(2, 1'b0); acc_addr = pick(0, 1'b0); acc_write = w[0];
      step();
      check("R12 idle", {wr_en, rd_zero, fault, rmt_ok}, 4'b0000);
    end

    // R7: execution region traps
    for (int b = 0; b < 8; b++)
      for (int pr = 0; pr < 4; pr++) begin
        bit ef;
        prot = 16'(b) << 8;
        pc_addr = pick(pr, b[0]);
        ef = (pr < 3) ? b[pr] : 1'b0;
        step();
        check("R7 exec guard", {wr_en, rd_zero, fault, rmt_ok}, {2'b00, ef, 1'b0});
      end

    // R8: instruction class traps (reserved bits 11,14,15 set too)
    pc_addr = pick(3, 1'b0);
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 4; k++) begin
        bit ef;
        prot = 16'hC800 | (16'(b) << 12);
        ins_kind = 2'(k);
        ef = (k == 1 || k == 2) ? b[0] : (k == 3) ? b[1] : 1'b0;
        step();
        check("R8 instr trap", {wr_en, rd_zero, fault, rmt_ok}, {2'b00, ef, 1'b0});
      end
    ins_kind = 2'd0;

    // R9: remote control-register write locks
    for (int r = 0; r < 2; r++)
      for (int l = 0; l < 4; l++)
        for (int s = 0; s < 8; s++)
          for (int v = 0; v < 2; v++) begin
            bit lk;
            run = r[0]; prot = 16'(l) << 6; rmt_sel = 3'(s); rmt_wr = v[0];
            lk = (s < 2) ? l[0] : (s < 6) ? l[1] : 1'b0;
            step();
            check("R9 remote lock", {wr_en, rd_zero, fault, rmt_ok},
                  {3'b000, v[0] & ~(r[0] & lk)});
          end
    rmt_wr = 1'b0;

    // R11: one-cycle latency, reset clears a live output
    run = 1'b0; acc_valid = 1'b1; acc_write = 1'b1;
    step();
    check("R11 latency", {wr_en, rd_zero, fault, rmt_ok}, 4'b1000);
    rst = 1'b1;
    step();
    check("R11 reset clear", {wr_en, rd_zero, fault, rmt_ok}, 4'b0000);
    rst = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule